// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block keeps the descriptor state for seven display fetch channels. Each channel follows a linked list of frame descriptors held in memory. A descriptor is four 32-bit words, read in this order: the next-descriptor pointer, the frame source address, the frame ID and the command word. On a `frame_start` pulse the block runs one load pass. First it zeroes the source register of every channel. Then it visits the channels in ascending order.

For each channel that `chan_en` enables, the block picks a descriptor address. A pending software branch request supplies the address if one exists; otherwise the stored next pointer does. If the address lies inside the valid memory window, the block fetches the four words over a request/valid word port and loads them into the channel's registers. After each enabled channel it emits a one-cycle event pulse: bus error, start-of-frame or end-of-frame. Pixel fetch and interrupt logic downstream consume these pulses. When every channel has been visited, the block pulses `pass_done`.

Software reaches the registers through a simple write/read port. The branch registers sit at `0x080 + 4*ch`. The per-channel registers sit at `0x200 + 16*ch`, with next pointer, source, ID and command at +0x0, +0x4, +0x8 and +0xC.

Top module: `dfc_top`

## Requirements
- R1: After reset every channel register reads zero, and `mem_req`, `pass_done` and all event outputs are low.
- R2: A write to a branch register (`0x080 + 4*ch`) stores the data ANDed with 0xFFFFFFF3. Bit 0 is the branch request, bit 1 is the branch event enable and bits 31:4 are the branch address.
- R3: A write to a next-pointer register (`0x200 + 16*ch`) stores the data with bits 3:0 forced to zero.
- R4: Writes to the source, ID and command registers (+0x4, +0x8, +0xC) have no effect. Reads of unmapped addresses return zero.
- R5: Every load pass starts by zeroing the source register of all channels, whether enabled or not, before any descriptor word is read.
- R6: A descriptor at byte address P is read as four single-word requests to P, P+4, P+8 and P+12, with at most one request outstanding. The returned words load next pointer, source, ID and command, in that order.
- R7: An enabled channel whose branch bit 0 is set takes its descriptor address from branch bits 31:4 and clears bit 0. It pulses its `ev_branch` bit only if branch bit 1 is set.
- R8: An enabled channel with no pending branch uses its stored next pointer, so successive passes follow the chain.
- R9: A descriptor address P with P < WIN_BASE or P+16 > WIN_BASE+WIN_SIZE causes no memory request. The channel's source stays zero.
- R10: After its descriptor step, an enabled channel whose source register is zero pulses its `ev_buserr` bit and no start-of-frame or end-of-frame event.
- R11: With a non-zero source and command bit 26 (palette load) clear, command bit 22 pulses `ev_sof` and bit 21 pulses `ev_eof` for that channel. With bit 26 set, neither pulses.
- R12: Channels are serviced in ascending index order. Disabled channels cause no memory request.
- R13: Each pass ends with exactly one single-cycle `pass_done` pulse, including a pass with no enabled channels. A `frame_start` that arrives during a pass is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a descriptor load pass when idle |
| chan_en | input | NCH | Per-channel enable |
| reg_addr | input | 12 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned word |
| ev_branch | output | NCH | Branch-taken event, per channel |
| ev_sof | output | NCH | Start-of-frame event, per channel |
| ev_eof | output | NCH | End-of-frame event, per channel |
| ev_buserr | output | NCH | Bus error event, per channel |
| pass_done | output | 1 | Load pass finished |

## Verification
The chain is walked over several passes.

- A plain next-pointer follow is compared against a taken branch with and without its event bit. This separates the branch path from the stored pointer path.
- Descriptors whose command words set the start-of-frame, end-of-frame and palette bits in different mixes, plus one with a zero source, separate the event rules from each other.
- A pass with two non-adjacent enabled channels exposes the service order and shows that a disabled channel's source is cleared.
- Pointers just below, at and just inside the window edges isolate the range check.
- A second start inside a busy pass and an empty pass confirm how `pass_done` is produced.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    localparam int REG_AW     = 12;
    localparam int BR_BASE    = 'h080;
    localparam int CH_BASE    = 'h200;
    localparam int CH_STRIDE  = 16;

    localparam logic [31:0] BR_WMASK = 32'hFFFF_FFF3;
    localparam logic [31:0] ND_WMASK = 32'hFFFF_FFF0;

    localparam int BR_REQ_BIT   = 0;
    localparam int BR_EVT_BIT   = 1;
    localparam int CMD_EOF_BIT  = 21;
    localparam int CMD_SOF_BIT  = 22;
    localparam int CMD_PAL_BIT  = 26;

    typedef logic [31:0] word_t;

    typedef enum logic [2:0] {
        S_IDLE, S_SCAN, S_REQ, S_WAIT, S_POST, S_DONE
    } seq_state_e;

    typedef struct packed {
        word_t nxt;
        word_t src;
        word_t fid;
        word_t cmd;
    } desc_t;

    typedef struct packed {
        word_t branch;
        desc_t d;
    } chan_regs_t;

    function automatic logic [REG_AW-1:0] br_addr(input int c);
        return REG_AW'(BR_BASE + 4 * c);
    endfunction

    function automatic logic [REG_AW-1:0] ch_addr(input int c, input int w);
        return REG_AW'(CH_BASE + CH_STRIDE * c + 4 * w);
    endfunction

    function automatic logic in_window(input word_t p, input word_t base, input word_t size);
        logic [32:0] lo, hi, top;
        lo  = {1'b0, p};
        hi  = {1'b0, p} + 33'd16;
        top = {1'b0, base} + {1'b0, size};
        return (lo >= {1'b0, base}) && (hi <= top);
    endfunction

endpackage

// File: rtl/dfc_chan.sv
module dfc_chan
    import dfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       br_we,
    input  logic       nd_we,
    input  word_t      wdata,
    input  logic       clr_src,
    input  logic       take_br,
    input  logic       ld_we,
    input  logic [1:0] ld_idx,
    input  word_t      ld_data,
    output chan_regs_t regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            // software write wins over the hardware clear of the request bit
            if (br_we)
                regs.branch <= wdata & BR_WMASK;
            else if (take_br)
                regs.branch[BR_REQ_BIT] <= 1'b0;

            if (ld_we && ld_idx == 2'd0)
                regs.d.nxt <= ld_data;
            else if (nd_we)
                regs.d.nxt <= wdata & ND_WMASK;

            if (clr_src)
                regs.d.src <= '0;
            else if (ld_we && ld_idx == 2'd1)
                regs.d.src <= ld_data;

            if (ld_we && ld_idx == 2'd2)
                regs.d.fid <= ld_data;
            if (ld_we && ld_idx == 2'd3)
                regs.d.cmd <= ld_data;
        end
    end

endmodule

// File: rtl/dfc_seq.sv
module dfc_seq
    import dfc_pkg::*;
#(
    parameter int    NCH      = 7,
    parameter word_t WIN_BASE = 32'h0000_1000,
    parameter word_t WIN_SIZE = 32'h0000_1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_start,
    input  logic [NCH-1:0]           chan_en,
    input  logic [NCH-1:0][31:0]     br_val,
    input  logic [NCH-1:0][31:0]     nd_val,
    input  logic [NCH-1:0][31:0]     src_val,
    input  logic [NCH-1:0]           cmd_sof,
    input  logic [NCH-1:0]           cmd_eof,
    input  logic [NCH-1:0]           cmd_pal,
    output logic                     clr_src,
    output logic [NCH-1:0]           take_br,
    output logic [NCH-1:0]           ld_we,
    output logic [1:0]               ld_idx,
    output word_t                    ld_data,
    output logic                     mem_req,
    output word_t                    mem_addr,
    input  logic                     mem_valid,
    input  word_t                    mem_rdata,
    output logic [NCH-1:0]           ev_branch,
    output logic [NCH-1:0]           ev_sof,
    output logic [NCH-1:0]           ev_eof,
    output logic [NCH-1:0]           ev_buserr,
    output logic                     done
);

    localparam int CW = $clog2(NCH + 1);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [CW-1:0] LAST = CW'(NCH);

    seq_state_e    st;
    logic [CW-1:0] ch;
    logic [IW-1:0] chs;
    logic [1:0]    widx;
    word_t         ptr;
    word_t         sel;
    logic          br_pend;
    logic          cur_en;

    assign chs     = (ch == LAST) ? '0 : IW'(ch);
    assign cur_en  = (ch != LAST) && chan_en[chs];
    assign br_pend = br_val[chs][BR_REQ_BIT];
    assign sel     = br_pend ? (br_val[chs] & ND_WMASK) : (nd_val[chs] & ND_WMASK);

    assign clr_src  = (st == S_IDLE) && frame_start;
    assign mem_req  = (st == S_REQ);
    assign mem_addr = ptr + {28'd0, widx, 2'b00};
    assign ld_idx   = widx;
    assign ld_data  = mem_rdata;
    assign done     = (st == S_DONE);

    always_comb begin
        take_br   = '0;
        ev_branch = '0;
        ld_we     = '0;
        ev_sof    = '0;
        ev_eof    = '0;
        ev_buserr = '0;
        for (int c = 0; c < NCH; c++) begin
            if (IW'(c) == chs) begin
                if (st == S_SCAN && cur_en && br_pend) begin
                    take_br[c]   = 1'b1;
                    ev_branch[c] = br_val[c][BR_EVT_BIT];
                end
                if (st == S_WAIT && mem_valid)
                    ld_we[c] = 1'b1;
                if (st == S_POST) begin
                    if (src_val[c] == '0) begin
                        ev_buserr[c] = 1'b1;
                    end else if (!cmd_pal[c]) begin
                        ev_sof[c] = cmd_sof[c];
                        ev_eof[c] = cmd_eof[c];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            ch   <= '0;
            widx <= '0;
            ptr  <= '0;
        end else begin
            case (st)
                S_IDLE: if (frame_start) begin
                    ch <= '0;
                    st <= S_SCAN;
                end
                S_SCAN: begin
                    if (ch == LAST) begin
                        st <= S_DONE;
                    end else if (!cur_en) begin
                        ch <= ch + 1'b1;
                    end else if (in_window(sel, WIN_BASE, WIN_SIZE)) begin
                        ptr  <= sel;
                        widx <= '0;
                        st   <= S_REQ;
                    end else begin
                        st <= S_POST;
                    end
                end
                S_REQ:  st <= S_WAIT;
                S_WAIT: if (mem_valid) begin
                    if (widx == 2'd3) begin
                        st <= S_POST;
                    end else begin
                        widx <= widx + 1'b1;
                        st   <= S_REQ;
                    end
                end
                S_POST: begin
                    ch <= ch + 1'b1;
                    st <= S_SCAN;
                end
                S_DONE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dfc_top.sv
module dfc_top
    import dfc_pkg::*;
#(
    parameter int    NCH      = 7,
    parameter word_t WIN_BASE = 32'h0000_1000,
    parameter word_t WIN_SIZE = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [NCH-1:0]    chan_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_valid,
    input  logic [31:0]       mem_rdata,
    output logic [NCH-1:0]    ev_branch,
    output logic [NCH-1:0]    ev_sof,
    output logic [NCH-1:0]    ev_eof,
    output logic [NCH-1:0]    ev_buserr,
    output logic              pass_done
);

    chan_regs_t              regs [NCH];
    logic [NCH-1:0][31:0]    br_val, nd_val, src_val;
    logic [NCH-1:0]          cmd_sof, cmd_eof, cmd_pal;
    logic [NCH-1:0]          br_we, nd_we, take_br, ld_we;
    logic [1:0]              ld_idx;
    word_t                   ld_data;
    logic                    clr_src;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign br_we[c] = reg_we && (reg_addr == br_addr(c));
        assign nd_we[c] = reg_we && (reg_addr == ch_addr(c, 0));

        dfc_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .br_we   (br_we[c]),
            .nd_we   (nd_we[c]),
            .wdata   (reg_wdata),
            .clr_src (clr_src),
            .take_br (take_br[c]),
            .ld_we   (ld_we[c]),
            .ld_idx  (ld_idx),
            .ld_data (ld_data),
            .regs    (regs[c])
        );

        assign br_val[c]  = regs[c].branch;
        assign nd_val[c]  = regs[c].d.nxt;
        assign src_val[c] = regs[c].d.src;
        assign cmd_sof[c] = regs[c].d.cmd[CMD_SOF_BIT];
        assign cmd_eof[c] = regs[c].d.cmd[CMD_EOF_BIT];
        assign cmd_pal[c] = regs[c].d.cmd[CMD_PAL_BIT];
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr == br_addr(c))    reg_rdata = regs[c].branch;
            if (reg_addr == ch_addr(c, 0)) reg_rdata = regs[c].d.nxt;
            if (reg_addr == ch_addr(c, 1)) reg_rdata = regs[c].d.src;
            if (reg_addr == ch_addr(c, 2)) reg_rdata = regs[c].d.fid;
            if (reg_addr == ch_addr(c, 3)) reg_rdata = regs[c].d.cmd;
        end
    end

    dfc_seq #(
        .NCH      (NCH),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .chan_en     (chan_en),
        .br_val      (br_val),
        .nd_val      (nd_val),
        .src_val     (src_val),
        .cmd_sof     (cmd_sof),
        .cmd_eof     (cmd_eof),
        .cmd_pal     (cmd_pal),
        .clr_src     (clr_src),
        .take_br     (take_br),
        .ld_we       (ld_we),
        .ld_idx      (ld_idx),
        .ld_data     (ld_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_valid   (mem_valid),
        .mem_rdata   (mem_rdata),
        .ev_branch   (ev_branch),
        .ev_sof      (ev_sof),
        .ev_eof      (ev_eof),
        .ev_buserr   (ev_buserr),
        .done        (pass_done)
    );

endmodule

// File: rtl/dfc_chk.sv
module dfc_chk #(
    parameter int NCH = 7
) (
    input logic           clk,
    input logic           rst,
    input logic           mem_req,
    input logic           mem_valid,
    input logic           pass_done,
    input logic [NCH-1:0] ev_branch,
    input logic [NCH-1:0] ev_sof,
    input logic [NCH-1:0] ev_eof,
    input logic [NCH-1:0] ev_buserr
);

    logic outst;

    always_ff @(posedge clk) begin
        if (rst)            outst <= 1'b0;
        else if (mem_req)   outst <= 1'b1;
        else if (mem_valid) outst <= 1'b0;
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req && !pass_done && ev_buserr == '0));

    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !outst);

    assert_branch_single_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ev_branch));

    assert_no_req_on_error_R9: assert property (@(posedge clk) disable iff (rst)
        (ev_buserr != '0) |-> !mem_req);

    assert_err_excludes_frame_ev_R10: assert property (@(posedge clk) disable iff (rst)
        (ev_buserr & (ev_sof | ev_eof)) == '0);

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        pass_done |=> !pass_done);

endmodule

bind dfc_top dfc_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_valid (mem_valid),
    .pass_done (pass_done),
    .ev_branch (ev_branch),
    .ev_sof    (ev_sof),
    .ev_eof    (ev_eof),
    .ev_buserr (ev_buserr)
);

// File: tb/sim_dfc_top.sv
module sim_dfc_top;

    localparam int NCH = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_start = 1'b0;
    logic [NCH-1:0]    chan_en = '0;
    logic [11:0]       reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mem_req;
    logic [31:0]       mem_addr;
    logic              mem_valid;
    logic [31:0]       mem_rdata;
    logic [NCH-1:0]    ev_branch, ev_sof, ev_eof, ev_buserr;
    logic              pass_done;

    always #2 clk = ~clk;

    dfc_top #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .frame_start(frame_start), .chan_en(chan_en),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .ev_branch(ev_branch), .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_buserr(ev_buserr),
        .pass_done(pass_done)
    );

    // memory model: window 0x1000..0x1FFF, reply one cycle after request
    logic [31:0] mem [0:1023];
    logic [31:0] req_log [0:63];
    int          req_n = 0;
    int          br_cnt = 0, sof_cnt = 0, eof_cnt = 0, done_cnt = 0;
    int          err_cnt [NCH];

    initial for (int i = 0; i < NCH; i++) err_cnt[i] = 0;

    always @(posedge clk) begin
        if (rst) begin
            mem_valid <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_valid <= 1'b0;
            if (mem_req) begin
                mem_valid <= 1'b1;
                mem_rdata <= mem[10'((mem_addr - 32'h1000) >> 2)];
                req_log[req_n % 64] <= mem_addr;
                req_n <= req_n + 1;
            end
            br_cnt   <= br_cnt + $countones(ev_branch);
            sof_cnt  <= sof_cnt + $countones(ev_sof);
            eof_cnt  <= eof_cnt + $countones(ev_eof);
            done_cnt <= done_cnt + (pass_done ? 1 : 0);
            for (int i = 0; i < NCH; i++)
                if (ev_buserr[i]) err_cnt[i] <= err_cnt[i] + 1;
        end
    end

    int nvec = 0;
    int nfail = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_frame(input logic [NCH-1:0] en);
        int d0;
        int t;
        d0 = done_cnt;
        @(negedge clk);
        chan_en     = en;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        t = 0;
        while (done_cnt == d0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (done_cnt == d0) chk("R13 pass timeout", 32'd0, 32'd1);
        repeat (2) @(negedge clk);
    endtask

    // {addr, write data, expected readback}
    localparam logic [75:0] VEC [11] = '{
        {12'h080, 32'hFFFF_FFFF, 32'hFFFF_FFF3},  // R2 ch0
        {12'h098, 32'h1234_5679, 32'h1234_5671},  // R2 ch6
        {12'h200, 32'h0000_100F, 32'h0000_1000},  // R3 ch0
        {12'h230, 32'h0ABC_DEF7, 32'h0ABC_DEF0},  // R3 ch3
        {12'h204, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 source
        {12'h228, 32'hDEAD_BEEF, 32'h0000_0000},  // R4 id
        {12'h25C, 32'hFFFF_FFFF, 32'h0000_0000},  // R4 command
        {12'h0FC, 32'h0000_0001, 32'h0000_0000},  // R4 unmapped
        {12'h080, 32'h0000_0000, 32'h0000_0000},  // R2 cleanup
        {12'h098, 32'h0000_0000, 32'h0000_0000},  // R2 cleanup
        {12'h230, 32'h0000_0000, 32'h0000_0000}   // R3 cleanup
    };

    initial begin
        logic [31:0] v;
        int r0, b0, s0, e0, x0, d0;

        for (int i = 0; i < 1024; i++) mem[i] = '0;
        mem[0]  = 32'h0000_1010; mem[1]  = 32'h8000_0000; mem[2]  = 32'h11; mem[3]  = 32'h0040_0010;
        mem[4]  = 32'h0000_1000; mem[5]  = 32'h8000_1000; mem[6]  = 32'h22; mem[7]  = 32'h0460_0000;
        mem[8]  = 32'h0000_1000; mem[9]  = 32'h0000_0000; mem[10] = 32'h33; mem[11] = 32'h0060_0000;
        mem[12] = 32'h0000_1040; mem[13] = 32'h0000_9000; mem[14] = 32'h44; mem[15] = 32'h0020_0000;
        mem[16] = 32'h0000_1030; mem[17] = 32'h0000_9100; mem[18] = 32'h55; mem[19] = 32'h0000_0000;
        mem[1020] = 32'h0000_1000; mem[1021] = 32'h0000_A000; mem[1022] = 32'h66; mem[1023] = 32'h0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(12'h200, v); chk("R1 next ptr", v, 32'h0);
        rd(12'h080, v); chk("R1 branch", v, 32'h0);
        chk("R1 outputs", {31'd0, mem_req | pass_done | (|ev_buserr)}, 32'h0);

        // register vectors: R2 R3 R4
        for (int i = 0; i < 11; i++) begin
            wr(VEC[i][75:64], VEC[i][63:32]);
            rd(VEC[i][75:64], v);
            chk($sformatf("R2/R3/R4 vector %0d", i), v, VEC[i][31:0]);
        end

        // pass A: ch0 from 0x1000, SOF set (R6 R11)
        wr(12'h200, 32'h1000);
        r0 = req_n; s0 = sof_cnt; e0 = eof_cnt; d0 = done_cnt;
        run_frame(7'b0000001);
        chk("R6 request count", req_n - r0, 4);
        chk("R6 word0 addr", req_log[r0 % 64], 32'h1000);
        chk("R6 word1 addr", req_log[(r0 + 1) % 64], 32'h1004);
        chk("R6 word3 addr", req_log[(r0 + 3) % 64], 32'h100C);
        rd(12'h200, v); chk("R6 next loaded", v, 32'h1010);
        rd(12'h204, v); chk("R6 source loaded", v, 32'h8000_0000);
        rd(12'h208, v); chk("R6 id loaded", v, 32'h11);
        rd(12'h20C, v); chk("R6 cmd loaded", v, 32'h0040_0010);
        chk("R11 sof raised", sof_cnt - s0, 1);
        chk("R11 eof quiet", eof_cnt - e0, 0);
        chk("R13 one done", done_cnt - d0, 1);

        // pass B: chain follow, palette frame (R8 R11)
        r0 = req_n; s0 = sof_cnt; e0 = eof_cnt;
        run_frame(7'b0000001);
        chk("R8 chain addr", req_log[r0 % 64], 32'h1010);
        rd(12'h208, v); chk("R8 id", v, 32'h22);
        chk("R11 palette no sof", sof_cnt - s0, 0);
        chk("R11 palette no eof", eof_cnt - e0, 0);

        // pass C: branch with event, zero source (R7 R10)
        wr(12'h080, 32'h0000_1023);
        r0 = req_n; b0 = br_cnt; s0 = sof_cnt; x0 = err_cnt[0];
        run_frame(7'b0000001);
        chk("R7 branch addr", req_log[r0 % 64], 32'h1020);
        rd(12'h080, v); chk("R7 request cleared", v, 32'h1022);
        chk("R7 branch event", br_cnt - b0, 1);
        chk("R10 bus error", err_cnt[0] - x0, 1);
        chk("R10 no sof", sof_cnt - s0, 0);
        rd(12'h208, v); chk("R7 id", v, 32'h33);

        // pass D: branch without event bit (R7)
        wr(12'h080, 32'h0000_1001);
        r0 = req_n; b0 = br_cnt;
        run_frame(7'b0000001);
        chk("R7 silent branch addr", req_log[r0 % 64], 32'h1000);
        chk("R7 no event", br_cnt - b0, 0);
        rd(12'h080, v); chk("R7 silent cleared", v, 32'h1000);

        // pass E: ch1 and ch4 only (R12 R5 R11 eof)
        wr(12'h210, 32'h1040);
        wr(12'h240, 32'h1030);
        r0 = req_n; e0 = eof_cnt;
        run_frame(7'b0010010);
        chk("R12 request count", req_n - r0, 8);
        chk("R12 ch1 first", req_log[r0 % 64], 32'h1040);
        chk("R12 ch4 second", req_log[(r0 + 4) % 64], 32'h1030);
        rd(12'h204, v); chk("R5 disabled source cleared", v, 32'h0);
        rd(12'h218, v); chk("R12 ch1 id", v, 32'h55);
        rd(12'h248, v); chk("R12 ch4 id", v, 32'h44);
        chk("R11 eof raised", eof_cnt - e0, 1);

        // window boundaries on ch2 (R9)
        wr(12'h220, 32'h0000_0000);
        r0 = req_n; x0 = err_cnt[2];
        run_frame(7'b0000100);
        chk("R9 below window no read", req_n - r0, 0);
        chk("R9 below window error", err_cnt[2] - x0, 1);
        rd(12'h224, v); chk("R9 source zero", v, 32'h0);
        wr(12'h220, 32'h0000_2000);
        r0 = req_n; x0 = err_cnt[2];
        run_frame(7'b0000100);
        chk("R9 past window no read", req_n - r0, 0);
        chk("R9 past window error", err_cnt[2] - x0, 1);
        wr(12'h220, 32'h0000_1FF0);
        r0 = req_n; x0 = err_cnt[2];
        run_frame(7'b0000100);
        chk("R9 last slot reads", req_n - r0, 4);
        chk("R9 last slot no error", err_cnt[2] - x0, 0);
        rd(12'h228, v); chk("R9 last slot id", v, 32'h66);

        // second start during a busy pass is ignored (R13)
        r0 = req_n; d0 = done_cnt;
        @(negedge clk);
        chan_en = 7'b0000001;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (3) @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (40) @(negedge clk);
        chk("R13 busy start ignored done", done_cnt - d0, 1);
        chk("R13 busy start ignored reads", req_n - r0, 4);

        // empty pass still completes (R13)
        r0 = req_n; d0 = done_cnt;
        run_frame(7'b0000000);
        chk("R13 empty pass done", done_cnt - d0, 1);
        chk("R12 empty pass no reads", req_n - r0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec + 1, nfail + 1);
        $finish;
    end

endmodule